// File: doc/BRIEF.md
# Windowed Pixel Address Stepper

This block holds the current pixel position for a 240 x 320 frame store with 18-bit pixels. It also produces the matching linear memory address. A host sets the column and the row through indexed register writes. The host also defines a rectangular region of interest with four bound registers: first column, last column, first row and last row. A pulse on `access_done` marks the end of each pixel access, and every such pulse moves the position by one. Stepping never leaves the rectangle. At the end of a row the column reloads from the opposite edge and the row advances. After the final pixel of the rectangle, the position returns to the corner where the scan began.

Two direction inputs choose, independently for each axis, whether that axis counts up or down. The linear address is formed as row times the frame width plus column. It follows the current position in the same cycle, so a memory can use it without further delay. Bus decoding and the pixel array itself sit outside the block.

Top module: `gram_win_addr`

## Requirements
- R1: After reset the column and row are 0, `lin_addr` is 0, and the rectangle covers the whole frame: columns 0 to 239 and rows 0 to 319.
- R2: A write (`reg_we`=1) takes effect on the next clock edge and acts according to `reg_idx`:
  - 0x20 loads the column from `reg_data[7:0]`.
  - 0x21 loads the row from `reg_data[8:0]`.
  - 0x50 sets the first column and 0x51 sets the last column, both from `reg_data[7:0]`.
  - 0x52 sets the first row and 0x53 sets the last row, both from `reg_data[8:0]`.
  - Any other index changes nothing.
- R3: Inside the rectangle, an `access_done` pulse moves the column by one and leaves the row as it is. The column goes up by one when `x_inc`=1 and the column is below the last column. It goes down by one when `x_inc`=0 and the column is above the first column.
- R4: A column at its exit edge reloads from the other edge on `access_done`, and the row steps by one in its own direction. The exit edge is at or beyond the last column when counting up, and at or below the first column when counting down. The row goes up when `y_inc`=1 and down when `y_inc`=0.
- R5: A row stepping from its exit edge reloads from its opposite edge. The exit edge is at or beyond the last row when counting up, and at or below the first row when counting down. Passing the final pixel of the rectangle therefore returns both axes to the starting corner.
- R6: With no `access_done` and no position write, the column and row hold their values.
- R7: A column or row write in the same cycle as `access_done` wins, and the step is dropped for both axes. A bound write in the same cycle as a step takes effect after the step, so the step still uses the previous bounds.
- R8: `lin_addr` equals row*240 + column of the current outputs, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index |
| reg_data | input | 16 | Register write data |
| access_done | input | 1 | One pulse per completed pixel access |
| x_inc | input | 1 | Column direction: 1 up, 0 down |
| y_inc | input | 1 | Row direction: 1 up, 0 down |
| cur_x | output | 8 | Current column |
| cur_y | output | 9 | Current row |
| lin_addr | output | 17 | Linear pixel address |

## Verification
Two events can land in one cycle: a step triggered by `access_done`, and a register write to a position or a bound. The bench forces both cases on purpose:
- It writes the column while a step pulse is present, and expects the written value with the row untouched.
- It rewrites the last column in the same cycle as a step taken at the old edge, and expects a wrap computed from the old bound.

Separately, every direction combination is swept across a small rectangle for more than two full passes. The bench compares each position and linear address against arithmetic computed in the bench.

// File: rtl/gwa_pkg.sv
package gwa_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_POS_X,
      SEL_POS_Y,
      SEL_X_LO,
      SEL_X_HI,
      SEL_Y_LO,
      SEL_Y_HI
   } reg_sel_e;

   function automatic reg_sel_e decode_idx(
      input logic [7:0] idx,
      input logic [7:0] i_px,
      input logic [7:0] i_py,
      input logic [7:0] i_xlo,
      input logic [7:0] i_xhi,
      input logic [7:0] i_ylo,
      input logic [7:0] i_yhi
   );
      reg_sel_e s;
      s = SEL_NONE;
      if (idx == i_px)       s = SEL_POS_X;
      else if (idx == i_py)  s = SEL_POS_Y;
      else if (idx == i_xlo) s = SEL_X_LO;
      else if (idx == i_xhi) s = SEL_X_HI;
      else if (idx == i_ylo) s = SEL_Y_LO;
      else if (idx == i_yhi) s = SEL_Y_HI;
      return s;
   endfunction

endpackage

// File: rtl/gwa_winregs.sv
module gwa_winregs #(
   parameter int H_PIXELS = 240,
   parameter int V_PIXELS = 320,
   parameter int DW       = 16,
   parameter int XW       = 8,
   parameter int YW       = 9,
   parameter logic [7:0] IDX_PX  = 8'h20,
   parameter logic [7:0] IDX_PY  = 8'h21,
   parameter logic [7:0] IDX_XLO = 8'h50,
   parameter logic [7:0] IDX_XHI = 8'h51,
   parameter logic [7:0] IDX_YLO = 8'h52,
   parameter logic [7:0] IDX_YHI = 8'h53
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [7:0]    idx,
   input  logic [DW-1:0] data,
   output logic          load_x,
   output logic          load_y,
   output logic [XW-1:0] x_val,
   output logic [YW-1:0] y_val,
   output logic [XW-1:0] x_lo,
   output logic [XW-1:0] x_hi,
   output logic [YW-1:0] y_lo,
   output logic [YW-1:0] y_hi
);
   import gwa_pkg::*;

   localparam logic [XW-1:0] X_LAST = XW'(H_PIXELS - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(V_PIXELS - 1);

   reg_sel_e sel;

   always_comb begin
      sel = we ? decode_idx(idx, IDX_PX, IDX_PY, IDX_XLO, IDX_XHI, IDX_YLO, IDX_YHI)
               : SEL_NONE;
   end

   assign load_x = (sel == SEL_POS_X);
   assign load_y = (sel == SEL_POS_Y);
   assign x_val  = data[XW-1:0];
   assign y_val  = data[YW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_lo <= '0;
         x_hi <= X_LAST;
         y_lo <= '0;
         y_hi <= Y_LAST;
      end else begin
         case (sel)
            SEL_X_LO: x_lo <= data[XW-1:0];
            SEL_X_HI: x_hi <= data[XW-1:0];
            SEL_Y_LO: y_lo <= data[YW-1:0];
            SEL_Y_HI: y_hi <= data[YW-1:0];
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/gwa_axis.sv
module gwa_axis #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         up,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic [W-1:0] pos,
   output logic         wrap
);
   logic at_exit;

   assign at_exit = up ? (pos >= hi) : (pos <= lo);
   assign wrap    = step && at_exit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (load) begin
         pos <= load_val;
      end else if (step) begin
         if (at_exit) pos <= up ? lo : hi;
         else         pos <= up ? pos + W'(1) : pos - W'(1);
      end
   end

endmodule

// File: rtl/gwa_linear.sv
module gwa_linear #(
   parameter int H_PIXELS  = 240,
   parameter int XW        = 8,
   parameter int YW        = 9,
   parameter int AW        = 17,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic [XW-1:0] x,
   input  logic [YW-1:0] y,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] HK = AW'(H_PIXELS);

   logic [AW-1:0] yw, xw;
   assign yw = AW'(y);
   assign xw = AW'(x);

   generate
      if (SHIFT_ADD && H_PIXELS == 240) begin : g_shift
         assign addr = (yw << 8) - (yw << 4) + xw;
      end else begin : g_mult
         assign addr = yw * HK + xw;
      end
   endgenerate

endmodule

// File: rtl/gram_win_addr.sv
module gram_win_addr #(
   parameter int H_PIXELS  = 240,
   parameter int V_PIXELS  = 320,
   parameter int DW        = 16,
   parameter bit SHIFT_ADD = 1'b1,
   parameter logic [7:0] IDX_PX  = 8'h20,
   parameter logic [7:0] IDX_PY  = 8'h21,
   parameter logic [7:0] IDX_XLO = 8'h50,
   parameter logic [7:0] IDX_XHI = 8'h51,
   parameter logic [7:0] IDX_YLO = 8'h52,
   parameter logic [7:0] IDX_YHI = 8'h53,
   localparam int XW = $clog2(H_PIXELS),
   localparam int YW = $clog2(V_PIXELS),
   localparam int AW = $clog2(H_PIXELS * V_PIXELS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [7:0]    reg_idx,
   input  logic [DW-1:0] reg_data,
   input  logic          access_done,
   input  logic          x_inc,
   input  logic          y_inc,
   output logic [XW-1:0] cur_x,
   output logic [YW-1:0] cur_y,
   output logic [AW-1:0] lin_addr
);

   generate
      if (H_PIXELS < 2 || V_PIXELS < 2) begin : g_bad_size
         $error("gram_win_addr: frame must be at least 2 x 2");
      end
      if (DW < YW || DW < XW) begin : g_bad_dw
         $error("gram_win_addr: data width narrower than an address field");
      end
   endgenerate

   logic          load_x, load_y, pos_wr;
   logic [XW-1:0] x_val, win_xs, win_xe;
   logic [YW-1:0] y_val, win_ys, win_ye;
   logic          x_wrap, y_wrap;

   gwa_winregs #(
      .H_PIXELS(H_PIXELS), .V_PIXELS(V_PIXELS), .DW(DW), .XW(XW), .YW(YW),
      .IDX_PX(IDX_PX), .IDX_PY(IDX_PY), .IDX_XLO(IDX_XLO),
      .IDX_XHI(IDX_XHI), .IDX_YLO(IDX_YLO), .IDX_YHI(IDX_YHI)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .data(reg_data),
      .load_x(load_x), .load_y(load_y), .x_val(x_val), .y_val(y_val),
      .x_lo(win_xs), .x_hi(win_xe), .y_lo(win_ys), .y_hi(win_ye)
   );

   assign pos_wr = load_x | load_y;

   gwa_axis #(.W(XW)) u_ax_x (
      .clk(clk), .rst_n(rst_n), .load(load_x), .load_val(x_val),
      .step(access_done & ~pos_wr), .up(x_inc),
      .lo(win_xs), .hi(win_xe), .pos(cur_x), .wrap(x_wrap)
   );

   gwa_axis #(.W(YW)) u_ax_y (
      .clk(clk), .rst_n(rst_n), .load(load_y), .load_val(y_val),
      .step(x_wrap), .up(y_inc),
      .lo(win_ys), .hi(win_ye), .pos(cur_y), .wrap(y_wrap)
   );

   gwa_linear #(
      .H_PIXELS(H_PIXELS), .XW(XW), .YW(YW), .AW(AW), .SHIFT_ADD(SHIFT_ADD)
   ) u_lin (
      .x(cur_x), .y(cur_y), .addr(lin_addr)
   );

endmodule

// File: rtl/gwa_checker.sv
module gwa_checker #(
   parameter int XW = 8,
   parameter int YW = 9,
   parameter logic [7:0] IDX_PX = 8'h20,
   parameter logic [7:0] IDX_PY = 8'h21
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic [7:0]    reg_idx,
   input logic          access_done,
   input logic          x_inc,
   input logic          y_inc,
   input logic [XW-1:0] cur_x,
   input logic [YW-1:0] cur_y,
   input logic [XW-1:0] win_xs,
   input logic [XW-1:0] win_xe,
   input logic [YW-1:0] win_ys,
   input logic [YW-1:0] win_ye
);
   logic pw, stp;
   assign pw  = reg_we && (reg_idx == IDX_PX || reg_idx == IDX_PY);
   assign stp = access_done && !pw;

   AST_X_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (stp && x_inc && cur_x < win_xe) |=> (cur_x == $past(cur_x) + XW'(1)) && $stable(cur_y)); // R3

   AST_X_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (stp && !x_inc && cur_x > win_xs) |=> (cur_x == $past(cur_x) - XW'(1)) && $stable(cur_y)); // R3

   AST_X_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (stp && x_inc && cur_x >= win_xe) |=> cur_x == $past(win_xs)); // R4

   AST_CORNER_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (stp && x_inc && y_inc && cur_x >= win_xe && cur_y >= win_ye)
      |=> (cur_x == $past(win_xs)) && (cur_y == $past(win_ys))); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!access_done && !pw) |=> $stable(cur_x) && $stable(cur_y)); // R6

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (access_done && reg_we && reg_idx == IDX_PX) |=> $stable(cur_y)); // R7

endmodule

bind gram_win_addr gwa_checker #(
   .XW(XW), .YW(YW), .IDX_PX(IDX_PX), .IDX_PY(IDX_PY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
   .access_done(access_done), .x_inc(x_inc), .y_inc(y_inc),
   .cur_x(cur_x), .cur_y(cur_y),
   .win_xs(win_xs), .win_xe(win_xe), .win_ys(win_ys), .win_ye(win_ye)
);

// File: tb/gram_win_addr_bench.sv
module gram_win_addr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_idx = '0;
   logic [15:0] reg_data = '0;
   logic        access_done = 1'b0;
   logic        x_inc = 1'b1;
   logic        y_inc = 1'b1;
   logic [7:0]  cur_x;
   logic [8:0]  cur_y;
   logic [16:0] lin_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int mx = 0, my = 0, mxs = 0, mxe = 239, mys = 0, mye = 319;

   always #2.5 clk = ~clk;

   gram_win_addr u_gram_win_addr (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
      .reg_data(reg_data), .access_done(access_done), .x_inc(x_inc),
      .y_inc(y_inc), .cur_x(cur_x), .cur_y(cur_y), .lin_addr(lin_addr)
   );

   task automatic chk(input string req);
      int ea;
      ea = my * 240 + mx;
      checks++;
      if (int'(cur_x) != mx || int'(cur_y) != my || int'(lin_addr) != ea) begin
         failures++;
         $display("FAIL %s: x=%0d y=%0d addr=%0d expected x=%0d y=%0d addr=%0d",
                  req, cur_x, cur_y, lin_addr, mx, my, ea);
      end
   endtask

   task automatic model_ystep();
      if (y_inc) begin
         if (my >= mye) my = mys; else my++;
      end else begin
         if (my <= mys) my = mye; else my--;
      end
   endtask

   task automatic cyc(input bit we, input logic [7:0] idx, input int data,
                      input bit acc, input string req);
      reg_we = we; reg_idx = idx; reg_data = data[15:0]; access_done = acc;
      @(posedge clk);
      if (we && (idx == 8'h20 || idx == 8'h21)) begin
         if (idx == 8'h20) mx = data & 255; else my = data & 511;
      end else if (acc) begin
         if (x_inc) begin
            if (mx >= mxe) begin mx = mxs; model_ystep(); end else mx++;
         end else begin
            if (mx <= mxs) begin mx = mxe; model_ystep(); end else mx--;
         end
      end
      if (we) begin
         case (idx)
            8'h50: mxs = data & 255;
            8'h51: mxe = data & 255;
            8'h52: mys = data & 511;
            8'h53: mye = data & 511;
            default: ;
         endcase
      end
      @(negedge clk);
      reg_we = 1'b0; access_done = 1'b0;
      chk(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset");
      cyc(1'b1, 8'h20, 238, 1'b0, "R2 load x");
      cyc(1'b0, 8'h00, 0, 1'b1, "R1 full width step");
      cyc(1'b0, 8'h00, 0, 1'b1, "R1 full width wrap");
      cyc(1'b1, 8'h21, 319, 1'b0, "R2 load y");
      cyc(1'b1, 8'h20, 239, 1'b0, "R2 load x");
      cyc(1'b0, 8'h00, 0, 1'b1, "R1 full frame corner R5");
      cyc(1'b1, 8'h21, 300, 1'b0, "R2 load y");
      cyc(1'b1, 8'h20, 200, 1'b0, "R2 load x");
      for (int k = 0; k < 4; k++) cyc(1'b0, 8'h00, 0, 1'b0, "R6 idle hold");
      cyc(1'b1, 8'h22, 17, 1'b0, "R2 other index ignored");
      cyc(1'b1, 8'h54, 5, 1'b1, "R2 other index ignored with step");
      // rectangle columns 3..6, rows 10..12
      cyc(1'b1, 8'h50, 3, 1'b0, "R2 x lo");
      cyc(1'b1, 8'h51, 6, 1'b0, "R2 x hi");
      cyc(1'b1, 8'h52, 10, 1'b0, "R2 y lo");
      cyc(1'b1, 8'h53, 12, 1'b0, "R2 y hi");
      for (int d = 0; d < 4; d++) begin
         x_inc = d[0]; y_inc = d[1];
         cyc(1'b1, 8'h20, x_inc ? 3 : 6, 1'b0, "R2 corner x");
         cyc(1'b1, 8'h21, y_inc ? 10 : 12, 1'b0, "R2 corner y");
         for (int s = 0; s < 27; s++)
            cyc(1'b0, 8'h00, 0, 1'b1, "R3 R4 R5 R8 sweep");
      end
      x_inc = 1'b1; y_inc = 1'b1;
      cyc(1'b1, 8'h20, 100, 1'b0, "R2 outside load");
      cyc(1'b0, 8'h00, 0, 1'b1, "R4 outside wraps in");
      cyc(1'b1, 8'h21, 0, 1'b0, "R2 y below");
      x_inc = 1'b0;
      cyc(1'b1, 8'h20, 1, 1'b0, "R2 x below");
      cyc(1'b0, 8'h00, 0, 1'b1, "R4 down from below lo");
      x_inc = 1'b1;
      cyc(1'b1, 8'h20, 4, 1'b0, "R2 x");
      cyc(1'b1, 8'h20, 50, 1'b1, "R7 x write beats step");
      cyc(1'b1, 8'h21, 11, 1'b1, "R7 y write beats step");
      cyc(1'b1, 8'h20, 6, 1'b0, "R2 x at edge");
      cyc(1'b1, 8'h51, 9, 1'b1, "R7 step uses old hi");
      cyc(1'b0, 8'h00, 0, 1'b1, "R3 new hi in force");
      cyc(1'b1, 8'h20, 9, 1'b0, "R2 x");
      cyc(1'b0, 8'h00, 0, 1'b1, "R4 wrap at new hi");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule